// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one entry from a flat page table in main memory. A base register gives the table's start address. The upper bits of the virtual address form the page number, and the lower bits form the in-page offset. On an accepted request, the walker forms the entry address from the base and the page number, and issues a single read on a plain request/response memory port. It then decodes the returned word.

A valid entry produces two outputs in the same cycle: the physical address (frame number joined to the untouched offset), and a fill record pairing the page number with the frame number, ready to be written into a translation buffer. An entry with its valid flag clear ends the walk with a fault flag raised and no fill record. Switching process context is done by writing a new base value and nothing else. The default shape is 32-bit virtual addresses with 4 KB pages, giving a 20-bit page number and a 12-bit offset, 20-bit frame numbers and 32-bit table entries.

Top module: `pgwalk`

## Requirements
- R1: When a walk succeeds, `rsp_paddr` equals the frame number in the upper bits and the request's offset bits, unchanged, in the lower `OFF_W` bits.
- R2: Each accepted request issues exactly one memory read. Its address is the base register value plus four times the page number, taken modulo 2^`ADDR_W`.
- R3: In a table entry, bit 31 is the valid flag and bits `PFN_W`-1:0 hold the frame number. All other entry bits have no effect on any output.
- R4: An entry with bit 31 clear completes with `rsp_fault`=1, `rsp_paddr`=0 and `fill_valid`=0.
- R5: A successful walk raises `fill_valid` for exactly the response cycle. In that cycle `fill_vpn` is the request's page number and `fill_pfn` is the decoded frame number.
- R6: A request is taken only when the walker is idle. `req_valid` seen while busy is ignored, and `rsp_valid` lasts one cycle per accepted request.
- R7: `busy` is 1 from the cycle after acceptance through the response cycle, and 0 in the cycle that follows.
- R8: The base register is the only state that changes on a context switch. A base write during a walk does not alter that walk's read address; it applies from the next accepted request.
- R9: While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` stays unchanged.
- R10: After synchronous reset, `busy`, `mem_req_valid`, `rsp_valid` and `fill_valid` are 0, and the base register reads as zero for the next walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | ADDR_W | New table base address |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Table read request |
| mem_req_addr | output | ADDR_W | Table entry address |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table entry word |
| rsp_valid | output | 1 | Translation result, one cycle |
| rsp_fault | output | 1 | Entry not valid |
| rsp_paddr | output | PFN_W+OFF_W | Physical address |
| fill_valid | output | 1 | Fill record present |
| fill_vpn | output | VPN_W | Fill record page number |
| fill_pfn | output | PFN_W | Fill record frame number |

## Verification
The bench builds the walker with a 4-bit page number, 4-bit offset, 6-bit frame number and 12-bit table address. With those widths every page number can be walked under three base values, one of which makes the entry address wrap past the top of the table space. The bench's memory model computes each entry from its address, sets junk in the unused entry bits, varies response latency and request stalls, and leaves some entries invalid so that faults mix with hits. Dedicated walks cover requests arriving while busy and base writes made in the middle of a walk.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    localparam int DEF_VPN_W   = 20;
    localparam int DEF_OFF_W   = 12;
    localparam int DEF_PFN_W   = 20;
    localparam int DEF_ADDR_W  = 32;
    localparam int ENTRY_W     = 32;
    localparam int ENT_VLD_BIT = 31;
    localparam int ENT_SHIFT   = 2;   // log2 of entry size in bytes

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_ISSUE,
        WS_WAIT,
        WS_DONE
    } walk_state_e;

endpackage

// File: rtl/pgwalk_base.sv
module pgwalk_base #(
    parameter int ADDR_W = pgwalk_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] base
);
    always_ff @(posedge clk) begin
        if (rst)     base <= '0;
        else if (we) base <= wdata;
    end
endmodule

// File: rtl/pgwalk_entry.sv
module pgwalk_entry #(
    parameter int PFN_W = pgwalk_pkg::DEF_PFN_W
) (
    input  logic [pgwalk_pkg::ENTRY_W-1:0] word,
    output logic                           vld,
    output logic [PFN_W-1:0]               pfn
);
    import pgwalk_pkg::*;

    // Bits between the frame field and the valid flag carry no meaning.
    logic unused_rsvd;
    assign unused_rsvd = ^word[ENT_VLD_BIT-1:PFN_W];

    assign vld = word[ENT_VLD_BIT];
    assign pfn = word[PFN_W-1:0];
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm #(
    parameter int VPN_W  = pgwalk_pkg::DEF_VPN_W,
    parameter int OFF_W  = pgwalk_pkg::DEF_OFF_W,
    parameter int PFN_W  = pgwalk_pkg::DEF_PFN_W,
    parameter int ADDR_W = pgwalk_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [ADDR_W-1:0] base,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic              ent_vld,
    input  logic [PFN_W-1:0]  ent_pfn,
    output logic              busy,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [PFN_W+OFF_W-1:0] rsp_paddr,
    output logic              fill_valid,
    output logic [VPN_W-1:0]  fill_vpn,
    output logic [PFN_W-1:0]  fill_pfn
);
    import pgwalk_pkg::*;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [OFF_W-1:0]  off;
        logic [ADDR_W-1:0] eaddr;
    } walk_ctx_t;

    typedef struct packed {
        logic             hit;
        logic [PFN_W-1:0] pfn;
    } walk_res_t;

    walk_state_e state;
    walk_ctx_t   ctx;
    walk_res_t   res;
    logic        accept;

    assign accept = req_valid && (state == WS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WS_IDLE;
            ctx   <= '0;
            res   <= '0;
        end else begin
            unique case (state)
                WS_IDLE: if (accept) begin
                    ctx.vpn   <= req_vpn;
                    ctx.off   <= req_off;
                    // Base is sampled here, so later writes only reach the next walk.
                    ctx.eaddr <= base + (ADDR_W'(req_vpn) << ENT_SHIFT);
                    state     <= WS_ISSUE;
                end
                WS_ISSUE: if (mem_req_ready) state <= WS_WAIT;
                WS_WAIT: if (mem_rsp_valid) begin
                    res.hit <= ent_vld;
                    res.pfn <= ent_pfn;
                    state   <= WS_DONE;
                end
                WS_DONE: state <= WS_IDLE;
                default: state <= WS_IDLE;
            endcase
        end
    end

    assign busy          = (state != WS_IDLE);
    assign mem_req_valid = (state == WS_ISSUE);
    assign mem_req_addr  = ctx.eaddr;
    assign rsp_valid     = (state == WS_DONE);
    assign rsp_fault     = rsp_valid && !res.hit;
    assign rsp_paddr     = res.hit ? {res.pfn, ctx.off} : '0;
    assign fill_valid    = rsp_valid && res.hit;
    assign fill_vpn      = ctx.vpn;
    assign fill_pfn      = res.pfn;

    p_hold_req_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_addr_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(mem_req_addr));

    p_fill_only_hit_r5: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> rsp_valid && !rsp_fault);

    p_fault_no_fill_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> !fill_valid && rsp_paddr == '0);

    p_single_rsp_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid && !busy);

    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy && mem_req_valid);

    p_read_in_walk_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid || rsp_valid) |-> busy);
endmodule

// File: rtl/pgwalk.sv
module pgwalk #(
    parameter int VPN_W  = pgwalk_pkg::DEF_VPN_W,
    parameter int OFF_W  = pgwalk_pkg::DEF_OFF_W,
    parameter int PFN_W  = pgwalk_pkg::DEF_PFN_W,
    parameter int ADDR_W = pgwalk_pkg::DEF_ADDR_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      base_we,
    input  logic [ADDR_W-1:0]         base_wdata,
    input  logic                      req_valid,
    input  logic [VPN_W+OFF_W-1:0]    req_vaddr,
    output logic                      busy,
    output logic                      mem_req_valid,
    output logic [ADDR_W-1:0]         mem_req_addr,
    input  logic                      mem_req_ready,
    input  logic                      mem_rsp_valid,
    input  logic [31:0]               mem_rsp_data,
    output logic                      rsp_valid,
    output logic                      rsp_fault,
    output logic [PFN_W+OFF_W-1:0]    rsp_paddr,
    output logic                      fill_valid,
    output logic [VPN_W-1:0]          fill_vpn,
    output logic [PFN_W-1:0]          fill_pfn
);
    import pgwalk_pkg::*;

    localparam int VA_W = VPN_W + OFF_W;

    initial begin
        if (PFN_W >= ENT_VLD_BIT) $error("frame field overlaps valid flag");
    end

    logic [ADDR_W-1:0] base;
    logic              ent_vld;
    logic [PFN_W-1:0]  ent_pfn;

    pgwalk_base #(.ADDR_W(ADDR_W)) u_base (
        .clk   (clk),
        .rst   (rst),
        .we    (base_we),
        .wdata (base_wdata),
        .base  (base)
    );

    pgwalk_entry #(.PFN_W(PFN_W)) u_entry (
        .word (mem_rsp_data),
        .vld  (ent_vld),
        .pfn  (ent_pfn)
    );

    pgwalk_fsm #(
        .VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .ADDR_W(ADDR_W)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_vpn       (req_vaddr[VA_W-1:OFF_W]),
        .req_off       (req_vaddr[OFF_W-1:0]),
        .base          (base),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .ent_vld       (ent_vld),
        .ent_pfn       (ent_pfn),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault),
        .rsp_paddr     (rsp_paddr),
        .fill_valid    (fill_valid),
        .fill_vpn      (fill_vpn),
        .fill_pfn      (fill_pfn)
    );
endmodule

// File: tb/pgwalk_bench.sv
module pgwalk_bench;
    localparam int VPN_W  = 4;
    localparam int OFF_W  = 4;
    localparam int PFN_W  = 6;
    localparam int ADDR_W = 12;
    localparam int VA_W   = VPN_W + OFF_W;
    localparam int PA_W   = PFN_W + OFF_W;

    logic              clk = 0;
    logic              rst = 1;
    logic              base_we = 0;
    logic [ADDR_W-1:0] base_wdata = '0;
    logic              req_valid = 0;
    logic [VA_W-1:0]   req_vaddr = '0;
    logic              busy, mem_req_valid, rsp_valid, rsp_fault, fill_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_req_ready = 0;
    logic              mem_rsp_valid = 0;
    logic [31:0]       mem_rsp_data = '0;
    logic [PA_W-1:0]   rsp_paddr;
    logic [VPN_W-1:0]  fill_vpn;
    logic [PFN_W-1:0]  fill_pfn;

    always #5 clk = ~clk;

    pgwalk #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .ADDR_W(ADDR_W)) u_pgwalk (
        .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn)
    );

    int tests = 0;
    int fails = 0;
    int lat_cfg = 1;
    int stall_left = 0;
    int pend = 0;
    int rd_count = 0;
    logic [ADDR_W-1:0] last_addr = '0;

    function automatic logic ent_ok(input logic [ADDR_W-1:0] a);
        return ((int'(a) >> 2) % 3) != 2;
    endfunction

    function automatic logic [PFN_W-1:0] ent_pfn(input logic [ADDR_W-1:0] a);
        return PFN_W'((int'(a) * 5 + 3) % 64);
    endfunction

    // Junk in the reserved bits (30:PFN_W) must not matter.
    function automatic logic [31:0] ent_word(input logic [ADDR_W-1:0] a);
        return {ent_ok(a), 31'h2A5A_5A40} | 32'(ent_pfn(a));
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: drives on falling edges.
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            mem_req_ready = 0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data  = ent_word(last_addr);
                end
            end else if (mem_req_valid === 1'b1) begin
                if (stall_left > 0) begin
                    stall_left--;
                end else begin
                    mem_req_ready = 1;
                    last_addr = mem_req_addr;
                    rd_count++;
                    pend = lat_cfg;
                end
            end
        end
    end

    // mode 0 plain, 1 extra requests while busy, 2 base write mid-walk
    task automatic walk(input logic [VA_W-1:0] va, input logic [ADDR_W-1:0] bse,
                        input int lat, input int stall, input int mode,
                        input logic [ADDR_W-1:0] nb);
        logic [VPN_W-1:0]  vpn = va[VA_W-1:OFF_W];
        logic [OFF_W-1:0]  off = va[OFF_W-1:0];
        logic [ADDR_W-1:0] ea  = bse + (ADDR_W'(vpn) << 2);
        int rd0;
        int n = 0;
        int rsp_seen = 0;
        @(negedge clk);
        lat_cfg = lat; stall_left = stall;
        rd0 = rd_count;
        req_valid = 1; req_vaddr = va;
        @(negedge clk);
        chk(busy === 1'b1, "R7 busy after accept", int'(busy), 1);
        req_valid = (mode == 1);
        req_vaddr = ~va;
        if (mode == 2) begin base_we = 1; base_wdata = nb; end
        while (rsp_valid !== 1'b1 && n < 50) begin
            @(negedge clk);
            base_we = 0;
            n++;
        end
        req_valid = 0;
        chk(rsp_valid === 1'b1, "R6 response seen", int'(rsp_valid), 1);
        chk(last_addr == ea, mode == 2 ? "R8 old base used" : "R2 entry address",
            int'(last_addr), int'(ea));
        chk(rd_count == rd0 + 1, "R2 one read", rd_count - rd0, 1);
        chk(busy === 1'b1, "R7 busy in response", int'(busy), 1);
        if (ent_ok(ea)) begin
            chk(rsp_fault === 1'b0, "R3 no fault", int'(rsp_fault), 0);
            chk(rsp_paddr == {ent_pfn(ea), off}, "R1 paddr",
                int'(rsp_paddr), int'({ent_pfn(ea), off}));
            chk(fill_valid === 1'b1 && fill_vpn == vpn && fill_pfn == ent_pfn(ea),
                "R5 fill record", int'({fill_valid, fill_vpn, fill_pfn}),
                int'({1'b1, vpn, ent_pfn(ea)}));
        end else begin
            chk(rsp_fault === 1'b1 && fill_valid === 1'b0 && rsp_paddr == '0,
                "R4 fault", int'({rsp_fault, fill_valid}), 2);
        end
        @(negedge clk);
        chk(rsp_valid === 1'b0 && busy === 1'b0, "R6 R7 single response then idle",
            int'({rsp_valid, busy}), 0);
        if (mode == 1) begin
            rsp_seen = 0;
            repeat (6) begin
                @(negedge clk);
                if (rsp_valid === 1'b1 || mem_req_valid === 1'b1) rsp_seen++;
            end
            chk(rsp_seen == 0 && rd_count == rd0 + 1, "R6 busy request ignored",
                rsp_seen, 0);
        end
    endtask

    task automatic set_base(input logic [ADDR_W-1:0] b);
        @(negedge clk);
        base_we = 1; base_wdata = b;
        @(negedge clk);
        base_we = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && mem_req_valid === 1'b0 && rsp_valid === 1'b0 &&
            fill_valid === 1'b0, "R10 reset outputs",
            int'({busy, mem_req_valid, rsp_valid, fill_valid}), 0);
        rst = 0;
        walk(8'h35, 12'h000, 1, 0, 0, '0);   // R10 base is zero after reset

        for (int b = 0; b < 3; b++) begin
            logic [ADDR_W-1:0] bv = (b == 0) ? 12'h000 : (b == 1) ? 12'h7C0 : 12'hFF0;
            set_base(bv);
            for (int v = 0; v < 16; v++) begin
                logic [OFF_W-1:0] of = OFF_W'((v * 3 + b * 5) % 16);
                walk({VPN_W'(v), of}, bv, v % 3 + 1, (v + b) % 3, 0, '0);  // R9 stalls
            end
        end

        set_base(12'h100);
        walk(8'h2F, 12'h100, 2, 1, 1, '0);
        walk(8'hA1, 12'h100, 1, 2, 2, 12'h400);
        walk(8'hA1, 12'h400, 1, 0, 0, '0);   // R8 new base for next walk

        rst = 1;
        @(negedge clk);
        rst = 0;
        walk(8'h70, 12'h000, 1, 0, 0, '0);   // R10 base cleared

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule